// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Character Packing

This block is a bus-attached asynchronous serial port. Software talks to it through a small register window: characters go out by writing a transmit-queue address, and characters come in by reading a receive-queue address. Both queues are 16 entries deep. Each direction can move data one character per bus word or four characters per 32-bit word. The line format is fixed at 8 data bits, no parity and one stop bit, with the least significant bit sent first.

A status word reports whether the receive queue holds data, whether the transmit queue can take another write, whether the transmitter has gone fully quiet, and two sticky loss flags. A command word enables the receiver and the transmitter one at a time. The same word carries an encoded field that flushes either direction without touching the configuration registers. In one-character receive mode, each received character carries its framing-error and break flags just above the data byte. Software can therefore drop or report corrupted input per character.

The bit rate comes from a clock-select register. It holds one 4-bit divider selector for the transmitter and another for the receiver.

Top module: `mm_uart`

## Requirements
- R1: After reset, the status word (offset 0xA4) reads 0x0C: bit 2 (transmit room) and bit 3 (transmitter quiet) are set, bit 0 (receive data), bit 4 (receive loss) and bit 5 (transmit loss) are clear. Mode register 2 (offset 0x04) reads 0x34, and the serial output idles high.
- R2: Mode register 1 (0x00), mode register 2 (0x04), the packing register (0x3C) and the clock-select register (0xA0) each store bits [7:0] of a write and return them on a read.
- R3: When packing bit 4 is set, a write to 0x100 queues one character, wdata[7:0]. It is sent as a low start bit, eight data bits LSB first and a high stop bit.
- R4: When packing bit 4 is clear, a write to 0x100 queues four characters, sent in the order wdata[7:0], [15:8], [23:16], [31:24].
- R5: When packing bit 5 is set, each received character becomes one queue entry. A read of 0x140 pops one entry and returns the data in [7:0], a framing error (stop bit low) in bit 8 and a break (all data bits and the stop bit low) in bit 9. Status bit 0 is set while the queue is not empty.
- R6: When packing bit 5 is clear, four received characters form one entry, with the first in [7:0] and the fourth in [31:24]. No entry appears before the fourth character arrives.
- R7: A read of 0x140 while the receive queue is empty returns 0 and does not change the queue.
- R8: The transmit queue holds 16 entries. Status bit 2 is clear while it is full. A write to a full queue is dropped and sets sticky status bit 5.
- R9: A character that arrives while the receive queue is full is discarded and sets sticky status bit 4. The entries already queued are kept.
- R10: Command (0xA8) bit 0 enables the receiver and bit 2 enables the transmitter; both are off after reset. A disabled transmitter keeps its queue and holds the line high. A disabled receiver ignores the line.
- R11: Command field [6:4] = 1 flushes the receive queue and clears both sticky flags. A value of 2 flushes the transmit queue and stops the shifter. Neither value changes the mode, packing or clock-select registers.
- R12: Status bit 3 is set only when the transmit queue is empty and no character is being shifted out.
- R13: One bit lasts 16*(n+1) clocks, where n is clock-select bits [3:0] for the transmitter and bits [7:4] for the receiver.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |

## Verification
A wrong queue count or pointer shows up on the first read of the receive address, or on the next character put on the wire: a repeated, missing or reordered byte appears within one frame time. A wrong word-packing index or a wrong shifter bit count corrupts the very first frame decoded from the output line. A wrong sticky flag, or a flush that misses some state, shows in the status word read one cycle after the offending access.

// File: rtl/muart_pkg.sv
package muart_pkg;

    localparam int unsigned UART_AW = 9;
    localparam int unsigned PER_W   = 16;

    // register window (software decodes these offsets)
    localparam logic [UART_AW-1:0] OFS_MODE1  = 9'h000;
    localparam logic [UART_AW-1:0] OFS_MODE2  = 9'h004;
    localparam logic [UART_AW-1:0] OFS_PACK   = 9'h03C;
    localparam logic [UART_AW-1:0] OFS_CLKSEL = 9'h0A0;
    localparam logic [UART_AW-1:0] OFS_STAT   = 9'h0A4;
    localparam logic [UART_AW-1:0] OFS_CMD    = 9'h0A8;
    localparam logic [UART_AW-1:0] OFS_TXQ    = 9'h100;
    localparam logic [UART_AW-1:0] OFS_RXQ    = 9'h140;

    localparam int unsigned PK_TX_SINGLE = 4;
    localparam int unsigned PK_RX_SINGLE = 5;
    localparam int unsigned CMD_RX_EN    = 0;
    localparam int unsigned CMD_TX_EN    = 2;

    typedef enum logic [2:0] {
        CMD_NOP    = 3'd0,
        CMD_RST_RX = 3'd1,
        CMD_RST_TX = 3'd2
    } cmd_code_e;

    typedef enum logic [1:0] {
        RXS_IDLE,
        RXS_START,
        RXS_DATA,
        RXS_STOP
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic [7:0] data;
    } rx_char_t;

    typedef struct packed {
        logic        single;
        logic [31:0] word;
    } tx_entry_t;

    typedef struct packed {
        logic tx_ovr;
        logic rx_ovf;
        logic tx_quiet;
        logic tx_room;
        logic rsvd;
        logic rx_avail;
    } status_t;

    function automatic logic [PER_W-1:0] bit_period(input logic [3:0] sel,
                                                    input int unsigned ovs);
        return PER_W'(ovs * (32'(sel) + 32'd1));
    endfunction

    function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] idx);
        case (idx)
            2'd0:    return w[7:0];
            2'd1:    return w[15:8];
            2'd2:    return w[23:16];
            default: return w[31:24];
        endcase
    endfunction

    function automatic logic [31:0] rx_single_word(input rx_char_t c);
        return {22'd0, c.brk, c.frm, c.data};
    endfunction

endpackage

// File: rtl/muart_fifo.sv
module muart_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !(rst || clr)) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/muart_tx_ser.sv
module muart_tx_ser
    import muart_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period,
    input  logic             load,
    input  logic [7:0]       din,
    output logic             busy,
    output logic             txd
);
    logic [9:0]       frame_q;
    logic [3:0]       nbit_q;
    logic [PER_W-1:0] cnt_q;

    assign txd = busy ? frame_q[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            frame_q <= '1;
            nbit_q  <= '0;
            cnt_q   <= '0;
        end else if (!busy) begin
            if (load) begin
                frame_q <= {1'b1, din, 1'b0};
                busy    <= 1'b1;
                nbit_q  <= '0;
                cnt_q   <= '0;
            end
        end else if (cnt_q == period - 1'b1) begin
            cnt_q   <= '0;
            frame_q <= {1'b1, frame_q[9:1]};
            if (nbit_q == 4'd9) busy <= 1'b0;
            else                nbit_q <= nbit_q + 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/muart_rx_des.sv
module muart_rx_des
    import muart_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    input  logic             rxd,
    output logic             valid,
    output rx_char_t         chr
);
    logic [1:0]       sync_q;
    logic             line;
    rx_state_e        state_q;
    logic [PER_W-1:0] cnt_q;
    logic [2:0]       nbit_q;
    logic [7:0]       shift_q;
    logic [PER_W-1:0] half;

    assign line = sync_q[1];
    assign half = period >> 1;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RXS_IDLE;
            cnt_q   <= '0;
            nbit_q  <= '0;
            shift_q <= '0;
            valid   <= 1'b0;
            chr     <= '0;
        end else begin
            valid <= 1'b0;
            case (state_q)
                RXS_IDLE: begin
                    cnt_q <= '0;
                    if (en && !line) state_q <= RXS_START;
                end
                RXS_START: begin
                    if (cnt_q == half - 1'b1) begin
                        cnt_q   <= '0;
                        nbit_q  <= '0;
                        state_q <= line ? RXS_IDLE : RXS_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RXS_DATA: begin
                    if (cnt_q == period - 1'b1) begin
                        cnt_q   <= '0;
                        shift_q <= {line, shift_q[7:1]};
                        if (nbit_q == 3'd7) state_q <= RXS_STOP;
                        else                nbit_q  <= nbit_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == period - 1'b1) begin
                        cnt_q    <= '0;
                        valid    <= 1'b1;
                        chr.data <= shift_q;
                        chr.frm  <= !line;
                        chr.brk  <= !line && (shift_q == 8'h00);
                        state_q  <= RXS_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mm_uart.sv
module mm_uart
    import muart_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned OVS   = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [UART_AW-1:0] bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               txd,
    input  logic               rxd
);
    logic [7:0] mode1_q, mode2_q, pack_q, clksel_q;
    logic       rx_en_q, tx_en_q;
    logic       rx_ovf_q, tx_ovr_q;

    logic       cmd_wr, rx_clr, tx_clr;
    logic       tx_single, rx_single;
    cmd_code_e  cmd_code;

    assign cmd_wr    = bus_wr && (bus_addr == OFS_CMD);
    assign cmd_code  = cmd_code_e'(bus_wdata[6:4]);
    assign rx_clr    = cmd_wr && (cmd_code == CMD_RST_RX);
    assign tx_clr    = cmd_wr && (cmd_code == CMD_RST_TX);
    assign tx_single = pack_q[PK_TX_SINGLE];
    assign rx_single = pack_q[PK_RX_SINGLE];

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            mode1_q  <= 8'h00;
            mode2_q  <= 8'h34;
            pack_q   <= 8'h00;
            clksel_q <= 8'h00;
            rx_en_q  <= 1'b0;
            tx_en_q  <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_MODE1:  mode1_q  <= bus_wdata[7:0];
                OFS_MODE2:  mode2_q  <= bus_wdata[7:0];
                OFS_PACK:   pack_q   <= bus_wdata[7:0];
                OFS_CLKSEL: clksel_q <= bus_wdata[7:0];
                OFS_CMD: begin
                    if (bus_wdata[CMD_RX_EN]) rx_en_q <= 1'b1;
                    if (bus_wdata[CMD_TX_EN]) tx_en_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // ---------------- transmit path ----------------
    tx_entry_t       txq_din, txq_dout;
    logic            txq_full, txq_empty, txq_push, txq_pop, tx_drop;
    logic [CW-1:0]   txq_cnt;
    logic [1:0]      tx_idx_q;
    logic            tx_last, tx_load, tx_busy;
    logic            tx_quiet;

    assign txq_push = bus_wr && (bus_addr == OFS_TXQ);
    assign tx_drop  = txq_push && txq_full;
    assign txq_din  = '{single: tx_single, word: bus_wdata};
    assign tx_last  = txq_dout.single || (tx_idx_q == 2'd3);
    assign tx_load  = tx_en_q && !txq_empty && !tx_busy && !tx_clr;
    assign txq_pop  = tx_load && tx_last;
    assign tx_quiet = txq_empty && !tx_busy;

    muart_fifo #(.W($bits(tx_entry_t)), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .clr   (tx_clr),
        .push  (txq_push),
        .din   (txq_din),
        .pop   (txq_pop),
        .dout  (txq_dout),
        .full  (txq_full),
        .empty (txq_empty),
        .count (txq_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst || tx_clr)  tx_idx_q <= '0;
        else if (tx_load)   tx_idx_q <= tx_last ? 2'd0 : tx_idx_q + 1'b1;
    end

    muart_tx_ser u_tx (
        .clk    (clk),
        .rst    (rst || tx_clr),
        .period (bit_period(clksel_q[3:0], OVS)),
        .load   (tx_load),
        .din    (pick_byte(txq_dout.word, tx_idx_q)),
        .busy   (tx_busy),
        .txd    (txd)
    );

    // ---------------- receive path ----------------
    logic            des_valid;
    rx_char_t        des_chr;
    logic [23:0]     asm_q;
    logic [1:0]      asm_k_q;
    logic            rx_push, rxq_push, rx_drop, rxq_pop;
    logic [31:0]     rx_din, rxq_dout;
    logic            rxq_full, rxq_empty;
    logic [CW-1:0]   rxq_cnt;

    muart_rx_des u_rx (
        .clk    (clk),
        .rst    (rst || rx_clr),
        .en     (rx_en_q),
        .period (bit_period(clksel_q[7:4], OVS)),
        .rxd    (rxd),
        .valid  (des_valid),
        .chr    (des_chr)
    );

    always_comb begin
        rx_push = 1'b0;
        rx_din  = '0;
        if (des_valid) begin
            if (rx_single) begin
                rx_push = 1'b1;
                rx_din  = rx_single_word(des_chr);
            end else if (asm_k_q == 2'd3) begin
                rx_push = 1'b1;
                rx_din  = {des_chr.data, asm_q};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || rx_clr) begin
            asm_q   <= '0;
            asm_k_q <= '0;
        end else if (des_valid && !rx_single) begin
            if (asm_k_q == 2'd3) begin
                asm_k_q <= '0;
            end else begin
                asm_q   <= {des_chr.data, asm_q[23:8]};
                asm_k_q <= asm_k_q + 1'b1;
            end
        end
    end

    assign rxq_push = rx_push && !rxq_full;
    assign rx_drop  = rx_push && rxq_full;
    assign rxq_pop  = bus_rd && (bus_addr == OFS_RXQ) && !rxq_empty;

    muart_fifo #(.W(32), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .clr   (rx_clr),
        .push  (rxq_push),
        .din   (rx_din),
        .pop   (rxq_pop),
        .dout  (rxq_dout),
        .full  (rxq_full),
        .empty (rxq_empty),
        .count (rxq_cnt)
    );

    // ---------------- sticky loss flags ----------------
    always_ff @(posedge clk) begin
        if (rst || rx_clr) begin
            rx_ovf_q <= 1'b0;
            tx_ovr_q <= 1'b0;
        end else begin
            if (rx_drop) rx_ovf_q <= 1'b1;
            if (tx_drop) tx_ovr_q <= 1'b1;
        end
    end

    // ---------------- read path ----------------
    status_t stat;
    assign stat = '{tx_ovr: tx_ovr_q, rx_ovf: rx_ovf_q, tx_quiet: tx_quiet,
                    tx_room: !txq_full, rsvd: 1'b0, rx_avail: !rxq_empty};

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                OFS_MODE1:  bus_rdata <= {24'd0, mode1_q};
                OFS_MODE2:  bus_rdata <= {24'd0, mode2_q};
                OFS_PACK:   bus_rdata <= {24'd0, pack_q};
                OFS_CLKSEL: bus_rdata <= {24'd0, clksel_q};
                OFS_STAT:   bus_rdata <= {26'd0, stat};
                OFS_RXQ:    bus_rdata <= rxq_empty ? 32'd0 : rxq_dout;
                default:    bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/muart_chk.sv
module muart_chk
    import muart_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic [UART_AW-1:0] bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [2:0]         cmd_field,
    input logic [31:0]        bus_rdata,
    input logic               txd,
    input logic               tx_quiet,
    input logic               txq_full,
    input logic               tx_ovr_q,
    input logic               rx_ovf_q,
    input logic [CW-1:0]      rxq_cnt,
    input logic [CW-1:0]      txq_cnt
);
    // R12
    quiet_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        tx_quiet |-> txd);

    // R8
    tx_full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_TXQ && txq_full) |=> tx_ovr_q);

    // R11
    rx_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CMD && cmd_field == 3'd1)
        |=> (rxq_cnt == '0 && !rx_ovf_q && !tx_ovr_q));

    // R11
    tx_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CMD && cmd_field == 3'd2) |=> (txq_cnt == '0));

    // R7
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_RXQ && rxq_cnt == '0) |=> (bus_rdata == 32'd0));

    // R8
    tx_depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        txq_cnt <= CW'(DEPTH));

    // R9
    rx_depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rxq_cnt <= CW'(DEPTH));
endmodule

bind mm_uart muart_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .cmd_field (bus_wdata[6:4]),
    .bus_rdata (bus_rdata),
    .txd       (txd),
    .tx_quiet  (tx_quiet),
    .txq_full  (txq_full),
    .tx_ovr_q  (tx_ovr_q),
    .rx_ovf_q  (rx_ovf_q),
    .rxq_cnt   (rxq_cnt),
    .txq_cnt   (txq_cnt)
);

// File: tb/mm_uart_bench.sv
`timescale 1ns/1ps
module mm_uart_bench;
    localparam logic [8:0] A_M1 = 9'h000, A_M2 = 9'h004, A_PK = 9'h03C, A_CS = 9'h0A0;
    localparam logic [8:0] A_ST = 9'h0A4, A_CMD = 9'h0A8, A_TX = 9'h100, A_RX = 9'h140;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        txd;
    logic        rxd = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mm_uart u_mm_uart (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .txd(txd), .rxd(rxd)
    );

    function automatic logic [31:0] exp_status(bit rx_av, bit tx_room, bit quiet, bit rx_ovf, bit tx_ovr);
        return {26'd0, tx_ovr, rx_ovf, quiet, tx_room, 1'b0, rx_av};
    endfunction

    function automatic logic [31:0] exp_rx_entry(logic [7:0] d, bit frm, bit brk);
        return {22'd0, brk, frm, d};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    // bench-side line driver: start, 8 data LSB first, stop
    task automatic send_frame(input int p, input logic [7:0] d, input bit stopv);
        @(negedge clk); rxd = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (p) @(negedge clk);
        end
        rxd = stopv;
        repeat (p) @(negedge clk);
        rxd = 1'b1;
        repeat (p) @(negedge clk);
    endtask

    // bench-side line decoder
    task automatic get_frame(input int p, output logic [7:0] d, output bit stop_ok);
        while (txd !== 1'b0) @(negedge clk);
        repeat (p / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (p) @(negedge clk);
            d[i] = txd;
        end
        repeat (p) @(negedge clk);
        stop_ok = (txd === 1'b1);
        repeat (p / 2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  b;
        logic [7:0]  sent [20];
        logic [31:0] w;
        bit          sok;
        int          n;

        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(A_ST, r); chk(r == exp_status(0, 1, 1, 0, 0), "R1 status", r, exp_status(0, 1, 1, 0, 0));
        rd_reg(A_M2, r); chk(r == 32'h34, "R1 mode2", r, 32'h34);
        chk(txd === 1'b1, "R1 txd idle", {31'd0, txd}, 32'd1);

        // R2 register storage
        wr_reg(A_M1, 32'hA5); rd_reg(A_M1, r); chk(r == 32'hA5, "R2 mode1", r, 32'hA5);
        wr_reg(A_CS, 32'h5A); rd_reg(A_CS, r); chk(r == 32'h5A, "R2 clksel", r, 32'h5A);
        wr_reg(A_CS, 32'h00);
        wr_reg(A_PK, 32'h30); rd_reg(A_PK, r); chk(r == 32'h30, "R2 pack", r, 32'h30);

        // R10 enable both directions
        wr_reg(A_CMD, 32'h05);

        // R3 single-character transmit, random bytes
        for (int k = 0; k < 6; k++) begin
            b = 8'($urandom);
            wr_reg(A_TX, {24'($urandom), b});
            get_frame(16, sent[0], sok);
            chk(sent[0] == b && sok, "R3 tx byte", {23'd0, sok, sent[0]}, {23'd0, 1'b1, b});
        end

        // R12 quiet only after queue and shifter drain
        wr_reg(A_TX, 32'h3C); wr_reg(A_TX, 32'hC3);
        rd_reg(A_ST, r); chk(r[3] == 1'b0, "R12 busy not quiet", r, {r[31:4], 1'b0, r[2:0]});
        get_frame(16, b, sok); chk(b == 8'h3C, "R3 tx first of pair", {24'd0, b}, 32'h3C);
        get_frame(16, b, sok); chk(b == 8'hC3, "R3 tx second of pair", {24'd0, b}, 32'hC3);
        repeat (20) @(negedge clk);
        rd_reg(A_ST, r); chk(r[3] == 1'b1, "R12 quiet after drain", r, {r[31:4], 1'b1, r[2:0]});

        // R13 transmit bit time with selector 1 -> 32 clocks
        wr_reg(A_CS, 32'h01);
        wr_reg(A_TX, 32'h01);
        while (txd !== 1'b0) @(negedge clk);
        n = 0;
        while (txd === 1'b0) begin n++; @(negedge clk); end
        chk(n == 32, "R13 tx bit length", n, 32);
        repeat (400) @(negedge clk);
        wr_reg(A_CS, 32'h00);

        // R4 packed transmit
        wr_reg(A_PK, 32'h20);
        for (int k = 0; k < 2; k++) begin
            w = $urandom;
            wr_reg(A_TX, w);
            for (int j = 0; j < 4; j++) begin
                get_frame(16, b, sok);
                chk(b == w[8*j +: 8], "R4 packed tx order", {24'd0, b}, {24'd0, w[8*j +: 8]});
            end
        end

        // R5 single-character receive
        wr_reg(A_PK, 32'h30);
        for (int k = 0; k < 4; k++) begin
            b = 8'($urandom);
            send_frame(16, b, 1'b1);
            rd_reg(A_ST, r); chk(r[0] == 1'b1, "R5 rx avail", r, r | 32'h1);
            rd_reg(A_RX, r); chk(r == exp_rx_entry(b, 0, 0), "R5 rx data", r, exp_rx_entry(b, 0, 0));
        end
        send_frame(16, 8'h5B, 1'b0);
        rd_reg(A_RX, r); chk(r == exp_rx_entry(8'h5B, 1, 0), "R5 framing flag", r, exp_rx_entry(8'h5B, 1, 0));
        send_frame(16, 8'h00, 1'b0);
        rd_reg(A_RX, r); chk(r == exp_rx_entry(8'h00, 1, 1), "R5 break flag", r, exp_rx_entry(8'h00, 1, 1));

        // R7 empty read
        rd_reg(A_RX, r); chk(r == 32'd0, "R7 empty read", r, 32'd0);
        rd_reg(A_ST, r); chk(r[0] == 1'b0, "R7 still empty", r, r & ~32'h1);

        // R13 receive bit time with selector 1 in [7:4]
        wr_reg(A_CS, 32'h10);
        send_frame(32, 8'hA7, 1'b1);
        rd_reg(A_RX, r); chk(r == exp_rx_entry(8'hA7, 0, 0), "R13 rx at slow rate", r, exp_rx_entry(8'hA7, 0, 0));
        wr_reg(A_CS, 32'h00);

        // R6 packed receive
        wr_reg(A_PK, 32'h10);
        w = $urandom;
        for (int j = 0; j < 3; j++) send_frame(16, w[8*j +: 8], 1'b1);
        rd_reg(A_ST, r); chk(r[0] == 1'b0, "R6 no entry before fourth", r, r & ~32'h1);
        send_frame(16, w[31:24], 1'b1);
        rd_reg(A_RX, r); chk(r == w, "R6 packed word", r, w);

        // R9 receive overflow
        wr_reg(A_PK, 32'h30);
        for (int k = 0; k < 17; k++) begin
            sent[k] = 8'($urandom);
            send_frame(16, sent[k], 1'b1);
        end
        rd_reg(A_ST, r); chk(r[4] == 1'b1, "R9 overflow sticky", r, r | 32'h10);
        for (int k = 0; k < 16; k++) begin
            rd_reg(A_RX, r);
            chk(r == exp_rx_entry(sent[k], 0, 0), "R9 kept entries", r, exp_rx_entry(sent[k], 0, 0));
        end
        rd_reg(A_RX, r); chk(r == 32'd0, "R9 new char discarded", r, 32'd0);

        // R11 receive flush clears flags, keeps config
        send_frame(16, 8'h11, 1'b1);
        wr_reg(A_CMD, 32'h10);
        rd_reg(A_ST, r); chk(r == exp_status(0, 1, 1, 0, 0), "R11 rx flush", r, exp_status(0, 1, 1, 0, 0));
        rd_reg(A_PK, r); chk(r == 32'h30, "R11 pack kept", r, 32'h30);

        // R8 / R10 transmit queue full with transmitter disabled
        @(negedge clk); rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
        for (int k = 0; k < 16; k++) wr_reg(A_TX, $urandom);
        rd_reg(A_ST, r); chk(r == exp_status(0, 0, 0, 0, 0), "R8 full no room", r, exp_status(0, 0, 0, 0, 0));
        chk(txd === 1'b1, "R10 disabled tx holds line", {31'd0, txd}, 32'd1);
        wr_reg(A_TX, 32'hFFFF_FFFF);
        rd_reg(A_ST, r); chk(r == exp_status(0, 0, 0, 0, 1), "R8 drop sticky", r, exp_status(0, 0, 0, 0, 1));

        // R11 transmit flush
        wr_reg(A_CMD, 32'h20);
        rd_reg(A_M2, r); chk(r == 32'h34, "R11 mode2 kept", r, 32'h34);
        rd_reg(A_ST, r); chk(r == exp_status(0, 1, 1, 0, 1), "R11 tx flush", r, exp_status(0, 1, 1, 0, 1));
        wr_reg(A_CMD, 32'h04);
        n = 0;
        for (int k = 0; k < 300; k++) begin @(negedge clk); if (txd !== 1'b1) n++; end
        chk(n == 0, "R11 nothing left to send", n, 0);

        // R10 disabled receiver ignores line
        wr_reg(A_PK, 32'h30);
        send_frame(16, 8'h66, 1'b1);
        rd_reg(A_ST, r); chk(r[0] == 1'b0, "R10 rx disabled", r, r & ~32'h1);
        wr_reg(A_CMD, 32'h01);
        send_frame(16, 8'h66, 1'b1);
        rd_reg(A_RX, r); chk(r == 32'h66, "R10 rx enabled", r, 32'h66);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule